// File: doc/BRIEF.md
# Octal DDR Pseudo-SRAM Transaction Engine

This block runs single transactions on an eight-line, double-data-rate pseudo-SRAM bus. A request port with a valid/ready handshake takes an operation (array read, array write, mode-register read, mode-register write), a 32-bit address and 16 bits of write data. For each request the engine lowers chip select and waits out the setup time. It then sends a doubled 16-bit opcode and the 32-bit address, gives the device a dummy gap, and moves one 16-bit data word. Chip select is held for the hold time after the last clock and kept high for a recovery gap before the next request.

The pad side is a DDR output/input register pair. `bus_dout_p`/`bus_din_p` carry the byte on the rising clock edge and `bus_dout_n`/`bus_din_n` the byte on the falling edge. `bus_clk_en` gates the device clock for the cycle, and `bus_oe` drives the data lines. Strobe-based capture is not used: read data is sampled in the fixed cycle that follows the dummy gap.

Top module: `opsram_xfer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transaction, `bus_cs_n` is 1, `bus_clk_en`, `bus_oe` and `done` are 0, and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while chip select is high and no transaction is running. With no request, the bus stays idle.
- R3: Chip select goes low 3 cycles before the first clocked cycle.
- R4: The command takes one clocked cycle. The opcode byte goes on both edges. `req_op` encodes 0 as array read (byte 0x00), 1 as array write (0x80), 2 as register read (0x40) and 3 as register write (0xC0).
- R5: The address takes the next two clocked cycles, most significant byte first. The first cycle carries addr[31:24] on the rising edge and addr[23:16] on the falling edge. The second cycle carries addr[15:8] and addr[7:0].
- R6: Dummy gap in clocked cycles with the lines released: 9 (18 bit-times) for both reads, 4 (8 bit-times) for array write, none for register write.
- R7: Write data follows in one clocked cycle, with wdata[15:8] on the rising edge and wdata[7:0] on the falling edge, not swapped.
- R8: For reads, `rdata` is {din_p, din_n} as sampled in the single clocked cycle after the dummy gap. Input values in any other cycle are ignored.
- R9: After the last clocked cycle, chip select stays low for 3 cycles with the clock stopped.
- R10: `done` is a one-cycle pulse on the first cycle with chip select high. `rdata` is valid in that cycle.
- R11: Chip select stays high for at least 2 cycles between transactions. A request that is waiting starts with exactly 2 high cycles.
- R12: `bus_oe` is 1 only in command, address and write-data cycles. It is 0 in dummy cycles, in read-data cycles and in every cycle with the clock stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | 0 array read, 1 array write, 2 reg read, 3 reg write |
| req_addr | input | 32 | Transaction address |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with done |
| done | output | 1 | Transaction complete pulse |
| bus_cs_n | output | 1 | Device chip select, active low |
| bus_clk_en | output | 1 | Device clock runs this cycle |
| bus_oe | output | 1 | Data line drive enable |
| bus_dout_p | output | 8 | Byte driven on rising edge |
| bus_dout_n | output | 8 | Byte driven on falling edge |
| bus_din_p | input | 8 | Byte captured on rising edge |
| bus_din_n | input | 8 | Byte captured on falling edge |

## Verification
A wrong phase counter or state shows at the pins within one transaction. The bus would show the clock or drive starting one cycle early or late, dummy gaps of the wrong length for an operation, or a misplaced `done`. The bench compares every cycle from acceptance to return to idle against a phase schedule built from the operation. Any shift therefore appears in the cycle where it happens. A capture in the wrong cycle returns the filler bytes placed on the inputs outside the data cycle, so `rdata` is wrong at the next `done`.

// File: rtl/opsram_xfer.sv
module opsram_xfer #(
  parameter int CS_SETUP      = 3,
  parameter int CS_HOLD       = 3,
  parameter int CS_GAP        = 2,
  parameter int RD_DUMMY_BITS = 18,
  parameter int WR_DUMMY_BITS = 8,
  parameter int DATA_BYTES    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [31:0]             req_addr,
  input  logic [8*DATA_BYTES-1:0] req_wdata,
  output logic [8*DATA_BYTES-1:0] rdata,
  output logic                    done,
  output logic                    bus_cs_n,
  output logic                    bus_clk_en,
  output logic                    bus_oe,
  output logic [7:0]              bus_dout_p,
  output logic [7:0]              bus_dout_n,
  input  logic [7:0]              bus_din_p,
  input  logic [7:0]              bus_din_n
);
  localparam int DW       = 8 * DATA_BYTES;
  localparam int DATA_CYC = DATA_BYTES / 2;
  localparam int RD_DCYC  = RD_DUMMY_BITS / 2;
  localparam int WR_DCYC  = WR_DUMMY_BITS / 2;
  localparam int CW       = $clog2(RD_DCYC + WR_DCYC + CS_SETUP + CS_HOLD + CS_GAP + DATA_CYC + 4);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_HOLD, S_GAP} st_t;

  st_t            st, nxt;
  logic [CW-1:0]  cnt, len, dcyc;
  logic [1:0]     op;
  logic [31:0]    addr_q;
  logic [DW-1:0]  wsh, rsh;
  logic [7:0]     opc;
  logic           last;

  assign opc  = {op[0], op[1], 6'd0};
  assign dcyc = (op == 2'd3) ? CW'(0) : (op[0] ? CW'(WR_DCYC) : CW'(RD_DCYC));

  always_comb begin
    len = CW'(1);
    nxt = S_IDLE;
    case (st)
      S_SETUP: begin len = CW'(CS_SETUP);   nxt = S_CMD; end
      S_CMD:   begin len = CW'(1);          nxt = S_ADDR; end
      S_ADDR:  begin len = CW'(2);          nxt = (dcyc == '0) ? S_DATA : S_DUMMY; end
      S_DUMMY: begin len = dcyc;            nxt = S_DATA; end
      S_DATA:  begin len = CW'(DATA_CYC);   nxt = S_HOLD; end
      S_HOLD:  begin len = CW'(CS_HOLD);    nxt = S_GAP; end
      S_GAP:   begin len = CW'(CS_GAP - 1); nxt = S_IDLE; end
      default: begin len = CW'(1);          nxt = S_IDLE; end
    endcase
  end

  assign last = (cnt == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      op     <= '0;
      addr_q <= '0;
      wsh    <= '0;
      rsh    <= '0;
    end else if (st == S_IDLE) begin
      if (req_valid) begin
        st     <= S_SETUP;
        cnt    <= '0;
        op     <= req_op;
        addr_q <= req_addr;
        wsh    <= req_wdata;
      end
    end else begin
      if (st == S_ADDR) addr_q <= addr_q << 16;
      if (st == S_DATA) begin
        if (op[0]) wsh <= wsh << 16;
        else       rsh <= DW'({rsh, bus_din_p, bus_din_n});
      end
      if (last) begin
        st  <= nxt;
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign bus_cs_n   = (st == S_IDLE) || (st == S_GAP);
  assign bus_clk_en = (st == S_CMD) || (st == S_ADDR) || (st == S_DUMMY) || (st == S_DATA);
  assign bus_oe     = (st == S_CMD) || (st == S_ADDR) || ((st == S_DATA) && op[0]);
  assign done       = (st == S_GAP) && (cnt == '0);
  assign rdata      = rsh;

  always_comb begin
    {bus_dout_p, bus_dout_n} = 16'h0000;
    if (st == S_CMD)                 {bus_dout_p, bus_dout_n} = {opc, opc};
    else if (st == S_ADDR)           {bus_dout_p, bus_dout_n} = addr_q[31:16];
    else if (st == S_DATA && op[0])  {bus_dout_p, bus_dout_n} = wsh[DW-1 -: 16];
  end
endmodule

module opsram_xfer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic bus_cs_n,
  input logic bus_clk_en,
  input logic bus_oe
);
  AST_OE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> bus_clk_en && !bus_cs_n); // R12
  AST_CLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) bus_clk_en |-> !bus_cs_n); // R3
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_cs_n) |-> !bus_clk_en ##1 !bus_clk_en ##1 !bus_clk_en); // R3
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_cs_n) |-> !$past(bus_clk_en, 1) && !$past(bus_clk_en, 2) && !$past(bus_clk_en, 3)); // R9
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_cs_n) |=> bus_cs_n); // R11
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(bus_cs_n)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> bus_cs_n && !bus_clk_en); // R2
endmodule

bind opsram_xfer opsram_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .bus_cs_n(bus_cs_n), .bus_clk_en(bus_clk_en), .bus_oe(bus_oe)
);

// File: tb/sim_opsram_xfer.sv
module sim_opsram_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rdata;
  logic        done, bus_cs_n, bus_clk_en, bus_oe;
  logic [7:0]  bus_dout_p, bus_dout_n;
  logic [7:0]  bus_din_p = 8'hEE, bus_din_n = 8'h11;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  opsram_xfer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata),
    .done(done), .bus_cs_n(bus_cs_n), .bus_clk_en(bus_clk_en), .bus_oe(bus_oe),
    .bus_dout_p(bus_dout_p), .bus_dout_n(bus_dout_n),
    .bus_din_p(bus_din_p), .bus_din_n(bus_din_n)
  );

  // {op, addr, wdata, read input word}
  localparam logic [65:0] VEC [6] = '{
    {2'd0, 32'h1234_5678, 16'h0000, 16'hA55A},
    {2'd1, 32'hDEAD_BEEF, 16'hC3E1, 16'h0000},
    {2'd2, 32'h0000_0002, 16'h0000, 16'h0D31},
    {2'd3, 32'h0000_0000, 16'h2B07, 16'h0000},
    {2'd1, 32'h00FF_0100, 16'h8001, 16'h0000},
    {2'd0, 32'hFFFF_FFFC, 16'h0000, 16'h7E00}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [65:0] v);
    logic [1:0]  op;
    logic [31:0] a;
    logic [15:0] wd, rd, exb;
    logic [7:0]  oc;
    logic [3:0]  act, exp;
    int d;
    op = v[65:64]; a = v[63:32]; wd = v[31:16]; rd = v[15:0];
    d  = (op == 2'd3) ? 0 : (op[0] ? 4 : 9);
    oc = {op[0], op[1], 6'd0};
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'bxx; req_addr = 'x; req_wdata = 'x;
    for (int k = 0; k <= 11 + d; k++) begin
      exp = {(k >= 10 + d), (k >= 3 && k <= 6 + d),
             (k == 3 || k == 4 || k == 5 || (k == 6 + d && op[0])), (k == 10 + d)};
      act = {bus_cs_n, bus_clk_en, bus_oe, done};
      if (k < 3)            check(act == exp, "R3 setup {cs,clk,oe,done}", act, exp);
      else if (k == 3)      check(act == exp, "R4 command {cs,clk,oe,done}", act, exp);
      else if (k < 6)       check(act == exp, "R5 address {cs,clk,oe,done}", act, exp);
      else if (k < 6 + d)   check(act == exp, "R6 dummy {cs,clk,oe,done}", act, exp);
      else if (k == 6 + d)  check(act == exp, "R12 data {cs,clk,oe,done}", act, exp);
      else if (k < 10 + d)  check(act == exp, "R9 hold {cs,clk,oe,done}", act, exp);
      else                  check(act == exp, "R10 release {cs,clk,oe,done}", act, exp);
      exb = (k == 3) ? {oc, oc} : (k == 4) ? a[31:16] : (k == 5) ? a[15:0] : wd;
      if (exp[1]) begin
        if (k == 3)      check({bus_dout_p, bus_dout_n} == exb, "R4 opcode bytes", {bus_dout_p, bus_dout_n}, exb);
        else if (k < 6)  check({bus_dout_p, bus_dout_n} == exb, "R5 address bytes", {bus_dout_p, bus_dout_n}, exb);
        else             check({bus_dout_p, bus_dout_n} == exb, "R7 write data bytes", {bus_dout_p, bus_dout_n}, exb);
      end
      check(req_ready == (k == 11 + d), "R2 ready only when idle", req_ready, (k == 11 + d));
      if (k == 10 + d && !op[0]) check(rdata == rd, "R8 read data", rdata, rd);
      if (k == 6 + d) begin bus_din_p = rd[15:8]; bus_din_n = rd[7:0]; end
      else            begin bus_din_p = 8'hEE;    bus_din_n = 8'h11;   end
      if (k != 11 + d) @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check({bus_cs_n, bus_clk_en, bus_oe, done, req_ready} == 5'b10001, "R1 reset state",
          {bus_cs_n, bus_clk_en, bus_oe, done, req_ready}, 5'b10001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({bus_cs_n, bus_clk_en, bus_oe} == 3'b100, "R2 no request keeps bus idle",
          {bus_cs_n, bus_clk_en, bus_oe}, 3'b100);

    foreach (VEC[i]) run_txn(VEC[i]);

    // back-to-back: second request waits while first runs
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 32'h4; req_wdata = 16'h0101;
    @(negedge clk);
    req_op = 2'd2; req_addr = 32'h8;
    hi = 0;
    for (int t = 0; t < 60 && bus_cs_n == 1'b0; t++) @(negedge clk);
    for (int t = 0; t < 60 && bus_cs_n == 1'b1; t++) begin hi++; @(negedge clk); end
    req_valid = 1'b0;
    check(hi == 2, "R11 chip select gap back-to-back", hi, 2);
    for (int t = 0; t < 60 && bus_cs_n == 1'b0; t++) @(negedge clk);
    check(done == 1'b1, "R10 done at second release", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", done, 0);

    // reset during a read dummy gap
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h10;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(bus_clk_en == 1'b1, "R6 clock runs in dummy", bus_clk_en, 1);
    rst_n = 1'b0;
    #1;
    check({bus_cs_n, bus_clk_en, bus_oe, done, req_ready} == 5'b10001, "R1 reset mid-transaction",
          {bus_cs_n, bus_clk_en, bus_oe, done, req_ready}, 5'b10001);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn({2'd1, 32'h0102_0304, 16'h5AA5, 16'h0000});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule